// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the horizontally microcoded control unit of a small 32-bit processor. Internally it has a read-only control store of 2048 microwords, each 41 bits wide, and a microinstruction register (MIR) that holds the word now in execution. Each microword carries three 6-bit register selects (A, B, C), each with a source-select bit. It also carries a memory read strobe, a memory write strobe, a 4-bit ALU function code, a 3-bit sequencing condition and an 11-bit jump target. The register file, the ALU and main memory sit outside the block. The block sees them only through the instruction register value, four status flags (n, z, v, c) and a memory-done handshake.

The next control-store address is chosen from the sequencing condition of the word in the MIR. The choices are: fall through to the next word, jump on one of the four flags, jump on instruction bit 13, jump unconditionally, or a 256-way dispatch built from the opcode bits. The instruction-bit-13 test lets microcode decode branch conditions by shifting the instruction one bit at a time past bit 13. While a word asserts a memory strobe, the sequencer holds that word until memory reports completion.

Microword fields, from bit 40 down to bit 0: A[40:35], AMUX[34], B[33:28], BMUX[27], C[26:21], CMUX[20], RD[19], WR[18], ALU[17:14], COND[13:11], JUMP[10:0].

Top module: `ucseq_top`

## Requirements
- R1: A synchronous active-high reset sets `upc` to 0 and the MIR to all zeros, so `mem_rd`, `mem_wr`, `alu_fn` and all three selects read 0. The first clock edge after reset is released loads control-store word 0 with `upc` = 0.
- R2: Word 0 is the fetch word. It drives `a_sel` = 32 (PC), `b_sel` = 32 (PC) and `c_sel` = 37 (IR), with `mem_rd` = 1, `mem_wr` = 0 and `alu_fn` = 0101 (AND, flags untouched). Its COND is 000.
- R3: While the MIR asserts `mem_rd` or `mem_wr` and `mem_done` is 0, `upc` and every control output hold their values. The next edge with `mem_done` = 1 advances the sequencer.
- R4: COND 000 moves to `upc`+1, and the jump field has no effect. Word 1, the dispatch word, follows the fetch word in this way.
- R5: COND 111 (word 1) dispatches to address {1, IR[31:30], F, 00}. F is IR[24:19] when IR[31:30] is not 00. When IR[31:30] = 00, F is {IR[24:22], 000}, so any branch (IR[31:30] = 00, IR[24:22] = 010) goes to 1088 whatever its displacement bits are.
- R6: COND 101 jumps to the jump field when IR[13] = 1, and otherwise falls through. Word 2 uses this test with target 20.
- R7: COND 001, 010, 011 and 100 jump to the jump field when n, z, v or c respectively is 1, and otherwise fall through. Words 3, 4, 5 and 6 apply these tests in that order, with targets 21, 22, 23 and 24.
- R8: COND 110 always jumps to the jump field. Word 1088 jumps to 2. Words 7, 20 to 24, 1536 and 1792 jump to 0. Every word not otherwise listed is a jump to 0 with `alu_fn` = 0101 and no strobe.
- R9: A select whose source bit is 1 is taken from the instruction and zero-extended to 6 bits: A from IR[18:14], B from IR[4:0], C from IR[29:25]. A select whose source bit is 0 is taken from the MIR. Word 1536 sets all three source bits, with `alu_fn` = 0000 and no strobe.
- R10: Word 1792 drives `mem_wr` = 1, `mem_rd` = 0, and takes A and B from the instruction. `mem_rd` and `mem_wr` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir | input | 32 | Instruction register value |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| mem_done | input | 1 | Memory has completed the pending read or write |
| upc | output | 11 | Control-store address of the word in the MIR |
| a_sel | output | 6 | Resolved A-bus register select |
| b_sel | output | 6 | Resolved B-bus register select |
| c_sel | output | 6 | Resolved C-bus register select |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| alu_fn | output | 4 | ALU function code |

## Verification
The hardest paths to reach are the deep ends of the branch-decoding chain. To land on word 24, a branch instruction must pass the dispatch and the entry jump with instruction bit 13 clear. After that, the n, z and v tests must all fail and only c may be set. The stimulus holds the instruction and flags steady over one full pass from fetch to return, and it repeats that pass with a different single flag set each time. Every address on the path is checked. The stall is reached by holding `mem_done` low, both on the fetch word and on the write word reached by dispatch.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

    localparam int CS_AW     = 11;
    localparam int CS_DEPTH  = 1 << CS_AW;
    localparam int RSEL_W    = 6;
    localparam int ALU_W     = 4;
    localparam int IR_W      = 32;
    localparam int NUM_SEL   = 3;
    localparam int IRSEL_W   = 5;

    typedef enum logic [2:0] {
        COND_NEXT   = 3'b000,
        COND_N      = 3'b001,
        COND_Z      = 3'b010,
        COND_V      = 3'b011,
        COND_C      = 3'b100,
        COND_IR13   = 3'b101,
        COND_JUMP   = 3'b110,
        COND_DECODE = 3'b111
    } cond_e;

    typedef struct packed {
        logic [RSEL_W-1:0] a;
        logic              amux;
        logic [RSEL_W-1:0] b;
        logic              bmux;
        logic [RSEL_W-1:0] c;
        logic              cmux;
        logic              rd;
        logic              wr;
        logic [ALU_W-1:0]  alu;
        cond_e             cond;
        logic [CS_AW-1:0]  jaddr;
    } uword_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam logic [RSEL_W-1:0] REG_PC       = 6'd32;
    localparam logic [RSEL_W-1:0] REG_IR       = 6'd37;
    localparam logic [ALU_W-1:0]  ALU_AND_KEEP = 4'b0101;
    localparam logic [ALU_W-1:0]  ALU_ADD_CC   = 4'b0000;

    localparam logic [CS_AW-1:0] UA_FETCH    = 11'd0;
    localparam logic [CS_AW-1:0] UA_DISPATCH = 11'd1;
    localparam logic [CS_AW-1:0] UA_BR_BODY  = 11'd2;
    localparam logic [CS_AW-1:0] UA_BR_TAIL  = 11'd7;
    localparam logic [CS_AW-1:0] UA_BR_HIT   = 11'd20;
    localparam logic [CS_AW-1:0] UA_BR_ENTRY = 11'd1088;
    localparam logic [CS_AW-1:0] UA_ALU_OP   = 11'd1536;
    localparam logic [CS_AW-1:0] UA_STORE    = 11'd1792;

    function automatic uword_t uw_jump(input logic [CS_AW-1:0] tgt);
        uword_t w;
        w       = '0;
        w.alu   = ALU_AND_KEEP;
        w.cond  = COND_JUMP;
        w.jaddr = tgt;
        return w;
    endfunction

    function automatic uword_t uw_test(input cond_e cc, input logic [CS_AW-1:0] tgt);
        uword_t w;
        w       = '0;
        w.alu   = ALU_AND_KEEP;
        w.cond  = cc;
        w.jaddr = tgt;
        return w;
    endfunction

    function automatic uword_t ucode_word(input logic [CS_AW-1:0] addr);
        uword_t w;
        w = uw_jump(UA_FETCH);
        case (addr)
            UA_FETCH: begin
                w      = '0;
                w.a    = REG_PC;
                w.b    = REG_PC;
                w.c    = REG_IR;
                w.rd   = 1'b1;
                w.alu  = ALU_AND_KEEP;
                w.cond = COND_NEXT;
            end
            UA_DISPATCH: begin
                w      = '0;
                w.alu  = ALU_AND_KEEP;
                w.cond = COND_DECODE;
            end
            UA_BR_ENTRY: w = uw_jump(UA_BR_BODY);
            11'd2:       w = uw_test(COND_IR13, UA_BR_HIT);
            11'd3:       w = uw_test(COND_N, UA_BR_HIT + 11'd1);
            11'd4:       w = uw_test(COND_Z, UA_BR_HIT + 11'd2);
            11'd5:       w = uw_test(COND_V, UA_BR_HIT + 11'd3);
            11'd6:       w = uw_test(COND_C, UA_BR_HIT + 11'd4);
            UA_BR_TAIL:  w = uw_jump(UA_FETCH);
            UA_ALU_OP: begin
                w      = uw_jump(UA_FETCH);
                w.amux = 1'b1;
                w.bmux = 1'b1;
                w.cmux = 1'b1;
                w.alu  = ALU_ADD_CC;
            end
            UA_STORE: begin
                w      = uw_jump(UA_FETCH);
                w.amux = 1'b1;
                w.bmux = 1'b1;
                w.wr   = 1'b1;
            end
            default:     w = uw_jump(UA_FETCH);
        endcase
        return w;
    endfunction

    function automatic logic [CS_AW-1:0] dispatch_addr(input logic [1:0] op,
                                                       input logic [5:0] op3);
        logic [5:0] fld;
        fld = (op == 2'b00) ? {op3[5:3], 3'b000} : op3;
        return {1'b1, op, fld, 2'b00};
    endfunction

endpackage

// File: rtl/ucseq_store.sv
module ucseq_store
    import ucseq_pkg::*;
#(
    parameter int AW = CS_AW
) (
    input  logic [AW-1:0] addr,
    output uword_t        word
);
    localparam int DEPTH = 1 << AW;

    logic [CS_AW-1:0] addr_ext;

    generate
        if (AW == CS_AW) begin : g_same
            assign addr_ext = addr;
        end else begin : g_pad
            assign addr_ext = CS_AW'(addr);
        end
    endgenerate

    always_comb begin
        if (int'(addr) < DEPTH) word = ucode_word(addr_ext);
        else                    word = uw_jump(UA_FETCH);
    end
endmodule

// File: rtl/ucseq_next.sv
module ucseq_next
    import ucseq_pkg::*;
(
    input  uword_t           mir,
    input  logic [CS_AW-1:0] upc,
    input  logic             boot,
    input  logic [1:0]       op,
    input  logic [5:0]       op3,
    input  logic             ir13,
    input  flags_t           flags,
    output logic [CS_AW-1:0] next_addr
);
    logic             take;
    logic [CS_AW-1:0] seq_addr;

    assign seq_addr = upc + CS_AW'(1);

    always_comb begin
        case (mir.cond)
            COND_N:    take = flags.n;
            COND_Z:    take = flags.z;
            COND_V:    take = flags.v;
            COND_C:    take = flags.c;
            COND_IR13: take = ir13;
            COND_JUMP: take = 1'b1;
            default:   take = 1'b0;
        endcase
    end

    always_comb begin
        if (boot)                          next_addr = UA_FETCH;
        else if (mir.cond == COND_DECODE)  next_addr = dispatch_addr(op, op3);
        else if (take)                     next_addr = mir.jaddr;
        else                               next_addr = seq_addr;
    end
endmodule

// File: rtl/ucseq_fieldsel.sv
module ucseq_fieldsel
    import ucseq_pkg::*;
(
    input  uword_t            mir,
    input  logic [IRSEL_W-1:0] ir_rs1,
    input  logic [IRSEL_W-1:0] ir_rs2,
    input  logic [IRSEL_W-1:0] ir_rd,
    output logic [RSEL_W-1:0] a_sel,
    output logic [RSEL_W-1:0] b_sel,
    output logic [RSEL_W-1:0] c_sel
);
    logic [RSEL_W-1:0]  from_mir [NUM_SEL];
    logic [IRSEL_W-1:0] from_ir  [NUM_SEL];
    logic               use_ir   [NUM_SEL];
    logic [RSEL_W-1:0]  chosen   [NUM_SEL];

    assign from_mir[0] = mir.a;
    assign from_mir[1] = mir.b;
    assign from_mir[2] = mir.c;
    assign from_ir[0]  = ir_rs1;
    assign from_ir[1]  = ir_rs2;
    assign from_ir[2]  = ir_rd;
    assign use_ir[0]   = mir.amux;
    assign use_ir[1]   = mir.bmux;
    assign use_ir[2]   = mir.cmux;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SEL; gi++) begin : g_sel
            assign chosen[gi] = use_ir[gi] ? RSEL_W'(from_ir[gi]) : from_mir[gi];
        end
    endgenerate

    assign a_sel = chosen[0];
    assign b_sel = chosen[1];
    assign c_sel = chosen[2];
endmodule

// File: rtl/ucseq_top.sv
module ucseq_top
    import ucseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IR_W-1:0]   ir,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic              mem_done,
    output logic [CS_AW-1:0]  upc,
    output logic [RSEL_W-1:0] a_sel,
    output logic [RSEL_W-1:0] b_sel,
    output logic [RSEL_W-1:0] c_sel,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ALU_W-1:0]  alu_fn
);
    uword_t           mir_q;
    uword_t           store_word;
    logic [CS_AW-1:0] upc_q;
    logic [CS_AW-1:0] next_addr;
    logic             boot_q;
    logic             advance_w;
    logic [2:0]       cond_w;
    logic [CS_AW-1:0] jaddr_w;
    flags_t           flags;

    assign flags     = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};
    assign advance_w = !((mir_q.rd || mir_q.wr) && !mem_done);
    assign cond_w    = mir_q.cond;
    assign jaddr_w   = mir_q.jaddr;

    ucseq_next u_next (
        .mir       (mir_q),
        .upc       (upc_q),
        .boot      (boot_q),
        .op        (ir[31:30]),
        .op3       (ir[24:19]),
        .ir13      (ir[13]),
        .flags     (flags),
        .next_addr (next_addr)
    );

    ucseq_store #(.AW(CS_AW)) u_store (
        .addr (next_addr),
        .word (store_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upc_q  <= UA_FETCH;
            mir_q  <= '0;
            boot_q <= 1'b1;
        end else if (advance_w) begin
            upc_q  <= next_addr;
            mir_q  <= store_word;
            boot_q <= 1'b0;
        end
    end

    ucseq_fieldsel u_sel (
        .mir    (mir_q),
        .ir_rs1 (ir[18:14]),
        .ir_rs2 (ir[4:0]),
        .ir_rd  (ir[29:25]),
        .a_sel  (a_sel),
        .b_sel  (b_sel),
        .c_sel  (c_sel)
    );

    assign upc    = upc_q;
    assign mem_rd = mir_q.rd;
    assign mem_wr = mir_q.wr;
    assign alu_fn = mir_q.alu;
endmodule

// File: rtl/ucseq_chk.sv
module ucseq_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_done,
    input logic        ir13,
    input logic [10:0] upc,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [2:0]  cond,
    input logic [10:0] jaddr,
    input logic        advance,
    input logic        boot
);
    // R3: a pending memory access freezes the sequencer
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && !mem_done) |=> ($stable(upc) && $stable(mem_rd) && $stable(mem_wr)));

    // R4: fall-through goes to the following word
    p_seq_next_r4: assert property (@(posedge clk) disable iff (rst)
        (advance && !boot && cond == 3'b000) |=> (upc == $past(upc) + 11'd1));

    // R5: dispatch lands in the upper half, aligned to four words
    p_dispatch_r5: assert property (@(posedge clk) disable iff (rst)
        (advance && !boot && cond == 3'b111) |=> (upc[10] && upc[1:0] == 2'b00));

    // R6: bit-13 test taken
    p_ir13_take_r6: assert property (@(posedge clk) disable iff (rst)
        (advance && !boot && cond == 3'b101 && ir13) |=> (upc == $past(jaddr)));

    // R8: unconditional jump
    p_jump_r8: assert property (@(posedge clk) disable iff (rst)
        (advance && !boot && cond == 3'b110) |=> (upc == $past(jaddr)));

    // R10: strobes exclusive
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));
endmodule

bind ucseq_top ucseq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_done (mem_done),
    .ir13     (ir[13]),
    .upc      (upc),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .cond     (cond_w),
    .jaddr    (jaddr_w),
    .advance  (advance_w),
    .boot     (boot_q)
);

// File: tb/tb_ucseq_top.sv
module tb_ucseq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ir = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic        mem_done = 1'b0;
    logic [10:0] upc;
    logic [5:0]  a_sel, b_sel, c_sel;
    logic        mem_rd, mem_wr;
    logic [3:0]  alu_fn;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ucseq_top dut (
        .clk(clk), .rst(rst), .ir(ir),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .mem_done(mem_done), .upc(upc),
        .a_sel(a_sel), .b_sel(b_sel), .c_sel(c_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .alu_fn(alu_fn)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] br_ir(input logic bit13);
        logic [31:0] v;
        v = {2'b00, 1'b0, 4'b1000, 3'b010, 22'h2A5A5};
        v[13] = bit13;
        return v;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        chk("R1 upc in reset", upc, 0);
        chk("R1 strobes in reset", {mem_rd, mem_wr}, 0);
        chk("R1 alu in reset", alu_fn, 0);
        chk("R1 selects in reset", {a_sel, b_sel, c_sel}, 0);
    endtask

    task automatic t_fetch_stall();
        ir = 32'hFFFF_FFFF;
        mem_done = 1'b0;
        rst = 1'b0;
        tick();
        chk("R1 first word", upc, 0);
        chk("R2 fetch rd", mem_rd, 1);
        chk("R2 fetch wr", mem_wr, 0);
        chk("R2 fetch a_sel", a_sel, 32);
        chk("R2 fetch b_sel", b_sel, 32);
        chk("R9 fetch c_sel from MIR", c_sel, 37);
        chk("R2 fetch alu", alu_fn, 5);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 fetch hold upc", upc, 0);
            chk("R3 fetch hold rd", mem_rd, 1);
        end
    endtask

    task automatic t_branch(input logic bit13, input logic n, input logic z,
                            input logic v, input logic c);
        logic fl [4];
        fl[0] = n; fl[1] = z; fl[2] = v; fl[3] = c;
        ir = br_ir(bit13);
        flag_n = n; flag_z = z; flag_v = v; flag_c = c;
        mem_done = 1'b1;
        tick(); chk("R4 fetch to dispatch", upc, 1);
        tick(); chk("R5 branch dispatch", upc, 1088);
        tick(); chk("R8 branch entry jump", upc, 2);
        tick();
        if (bit13) begin
            chk("R6 ir13 taken", upc, 20);
            tick(); chk("R8 return to fetch", upc, 0);
            return;
        end
        chk("R6 ir13 not taken", upc, 3);
        for (int k = 0; k < 4; k++) begin
            tick();
            if (fl[k]) begin
                chk("R7 flag taken", upc, 21 + k);
                tick(); chk("R8 return to fetch", upc, 0);
                return;
            end
            chk("R7 flag not taken", upc, 4 + k);
        end
        tick(); chk("R8 tail to fetch", upc, 0);
    endtask

    task automatic t_alu_op();
        ir = {2'b10, 5'd5, 6'b000000, 5'd7, 1'b0, 8'hA5, 5'd9};
        mem_done = 1'b1;
        tick(); chk("R4 fetch to dispatch", upc, 1);
        tick(); chk("R5 alu dispatch", upc, 1536);
        chk("R9 a_sel from IR", a_sel, 7);
        chk("R9 b_sel from IR", b_sel, 9);
        chk("R9 c_sel from IR", c_sel, 5);
        chk("R9 alu code", alu_fn, 0);
        chk("R9 no strobe", {mem_rd, mem_wr}, 0);
        tick(); chk("R8 alu return", upc, 0);
        ir = {2'b10, 5'd1, 6'b111111, 5'd2, 1'b1, 8'h00, 5'd3};
        tick(); chk("R4 fetch to dispatch", upc, 1);
        tick(); chk("R5 op3 field dispatch", upc, 1788);
        chk("R8 default alu", alu_fn, 5);
        tick(); chk("R8 default return", upc, 0);
    endtask

    task automatic t_store();
        ir = {2'b11, 5'd3, 6'b000000, 5'd12, 1'b0, 8'h00, 5'd17};
        mem_done = 1'b1;
        tick(); chk("R4 fetch to dispatch", upc, 1);
        mem_done = 1'b0;
        tick(); chk("R5 store dispatch", upc, 1792);
        chk("R10 write strobe", mem_wr, 1);
        chk("R10 no read strobe", mem_rd, 0);
        chk("R10 a_sel from IR", a_sel, 12);
        chk("R10 b_sel from IR", b_sel, 17);
        tick(); tick();
        chk("R3 write hold upc", upc, 1792);
        chk("R3 write hold wr", mem_wr, 1);
        mem_done = 1'b1;
        tick(); chk("R3 write release", upc, 0);
    endtask

    initial begin
        t_reset();
        t_fetch_stall();
        t_branch(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        t_branch(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        t_branch(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        t_branch(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        t_branch(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        t_branch(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        t_alu_op();
        t_store();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule